// File: doc/BRIEF.md
# Receive Interrupt Moderation Controller

This block is the interrupt unit of a network controller. It collects event pulses from the receive and transmit DMA paths, the transmit MAC, the statistics counters and the host bus, latches each one as a cause bit in a status word, and drives a single level interrupt line from the causes that are enabled in a mask register. Software reaches it through a small register read/write port.

To keep a heavily loaded receive path from swamping the host, the unit has a one-shot countdown timer that runs on a 3.2 µs tick. A typical handler reads the acknowledge alias of the status register. That read returns the pending causes, clears them and clears the mask. When the handler sees a receive cause, it loads the countdown and re-enables every cause except receive. When the countdown reaches zero it raises a software-interrupt cause. The handler then picks up all the receive work that has piled up and enables the receive cause again. A moderation time converts to ticks as (time_us × 10) / 32, so 150 µs becomes 46 ticks. A moderation time of zero means the timer is never loaded and receive causes stay enabled, so they reach the line at once.

Top module: `rxim_ctrl`

## Requirements
- R1: After reset the status, mask, countdown and tick-rate registers all read zero and irq_o is low.
- R2: A one-cycle pulse on an event input sets its status bit on the next clock edge. The bits are host error 1, transmit done 2, transmit DMA done 3, receive DMA done 4, statistics overflow 5 and software interrupt 6. Writing ones to the status register (address 0) clears those bits, and writing 0xFFFF clears every cause.
- R3: irq_o is high exactly when some status bit and its mask bit (address 2) are both set. Bit 0 of the status word reads as the same value, and it reads 0 whenever the mask is zero.
- R4: A read of the acknowledge alias (address 1) returns the same word as a status read. On that edge it clears every cause bit and sets the mask register to zero.
- R5: An event that arrives on the same edge as an acknowledge read or a write-one-to-clear of its own bit leaves that bit set.
- R6: A write of N to the countdown register (address 3) loads it and restarts the tick divider. The countdown then decreases by one per tick. With a 100 MHz clock and rate 0, a tick is 320 cycles. The software-interrupt bit is set exactly N×320 edges after the write edge, and only once.
- R7: Writing 0 to the countdown register cancels a running countdown, and no software interrupt follows.
- R8: The tick-rate register (address 4, 2 bits) sets the tick period to 320 cycles shifted left by its value. With rate 1, a load of N expires after N×640 edges.
- R9: A moderation time converts to ticks as (us×10)/32, giving 46 for 150 µs and 0 for 0. When receive is masked off, a receive event does not raise irq_o until the countdown expiry sets the software-interrupt cause. With moderation off and receive enabled, a receive event raises irq_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe; takes priority over a read in the same cycle |
| rd_en_i | input | 1 | Register read strobe; only matters for the acknowledge alias |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |
| rx_dma_done_i | input | 1 | Receive DMA done pulse |
| tx_dma_done_i | input | 1 | Transmit DMA done pulse |
| tx_done_i | input | 1 | Transmit done pulse |
| stats_oflow_i | input | 1 | Statistics overflow pulse |
| host_err_i | input | 1 | Host error pulse |
| irq_o | output | 1 | Level interrupt line |

## Verification
A wrong status or mask state shows on irq_o and in bit 0 of a status read on the very next cycle, because the line is a direct function of those two registers. A wrong countdown or divider state does not show so quickly. It appears only as a software interrupt that comes one tick early or late, or never comes. For that reason the bench samples the status word on the edge just before the expected expiry edge and on the expiry edge itself. A wrong acknowledge side effect is visible in the next read of the mask register and in a line that stays high.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
  localparam int STAT_W = 16;

  localparam int B_LATCH  = 0;
  localparam int B_HOST   = 1;
  localparam int B_TXDONE = 2;
  localparam int B_TXDMA  = 3;
  localparam int B_RXDMA  = 4;
  localparam int B_STATS  = 5;
  localparam int B_SOFT   = 6;

  localparam logic [STAT_W-1:0] CAUSE_MASK = 16'h007E;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_ACK    = 3'd1,
    A_MASK   = 3'd2,
    A_COUNT  = 3'd3,
    A_RATE   = 3'd4
  } reg_addr_e;

  function automatic int unsigned usecs_to_ticks(input int unsigned us);
    return (us * 10) / 32;
  endfunction
endpackage

// File: rtl/rxim_tick_gen.sv
module rxim_tick_gen #(
  parameter int BASE_DIV = 320,
  parameter int RATE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              restart_i,
  output logic              tick_o
);
  localparam int MAX_DIV = BASE_DIV * (2 ** ((2 ** RATE_W) - 1));
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] period;

  assign period = DIV_W'(BASE_DIV) << rate_i;
  // >= keeps the divider safe when the rate shrinks mid-period
  assign tick_o = (div_q >= period - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (tick_o)    div_q <= '0;
    else                div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/rxim_countdown.sv
module rxim_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/rxim_irq_regs.sv
module rxim_irq_regs
  import rxim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic              w1c_i,
  input  logic              ack_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status_q, mask_q, clr, status_d;

  always_comb begin
    clr = '0;
    if (w1c_i)      clr = wdata_i;
    else if (ack_i) clr = '1;
    // set after clear: a same-edge event survives
    status_d = ((status_q & ~clr) | set_i) & CAUSE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      if (mask_wr_i)  mask_q <= wdata_i & CAUSE_MASK;
      else if (ack_i) mask_q <= '0;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/rxim_ctrl.sv
module rxim_ctrl
  import rxim_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int CNT_W       = 16,
  parameter int RATE_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [2:0]        addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic              rx_dma_done_i,
  input  logic              tx_dma_done_i,
  input  logic              tx_done_i,
  input  logic              stats_oflow_i,
  input  logic              host_err_i,
  output logic              irq_o
);
  // clock cycles per 3.2 us tick
  localparam int BASE_DIV = ((CLK_FREQ_HZ / 1000) * 32) / 10000;

  logic              wr_status, wr_mask, wr_count, wr_rate, ack;
  logic [RATE_W-1:0] rate_q;
  logic              tick, expire;
  logic [CNT_W-1:0]  cnt_q;
  logic [STAT_W-1:0] set_vec, status_q, mask_q;

  assign wr_status = wr_en_i && (addr_i == A_STATUS);
  assign wr_mask   = wr_en_i && (addr_i == A_MASK);
  assign wr_count  = wr_en_i && (addr_i == A_COUNT);
  assign wr_rate   = wr_en_i && (addr_i == A_RATE);
  assign ack       = rd_en_i && !wr_en_i && (addr_i == A_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_q <= '0;
    else if (wr_rate) rate_q <= wdata_i[RATE_W-1:0];
  end

  rxim_tick_gen #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_i    (rate_q),
    .restart_i (wr_count),
    .tick_o    (tick)
  );

  rxim_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_count),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .tick_i     (tick),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[B_HOST]   = host_err_i;
    set_vec[B_TXDONE] = tx_done_i;
    set_vec[B_TXDMA]  = tx_dma_done_i;
    set_vec[B_RXDMA]  = rx_dma_done_i;
    set_vec[B_STATS]  = stats_oflow_i;
    set_vec[B_SOFT]   = expire;
  end

  rxim_irq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .w1c_i     (wr_status),
    .ack_i     (ack),
    .mask_wr_i (wr_mask),
    .wdata_i   (wdata_i),
    .status_o  (status_q),
    .mask_o    (mask_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    case (reg_addr_e'(addr_i))
      A_STATUS, A_ACK: rdata_o = {status_q[STAT_W-1:1], irq_o};
      A_MASK:          rdata_o = mask_q;
      A_COUNT:         rdata_o = STAT_W'(cnt_q);
      A_RATE:          rdata_o = STAT_W'(rate_q);
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rxim_ctrl_chk.sv
module rxim_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic [2:0]  addr_i,
  input logic        wdata_txdone_i,
  input logic        rx_dma_done_i,
  input logic        tx_done_i,
  input logic        irq_o,
  input logic [15:0] status_q,
  input logic [15:0] mask_q,
  input logic [15:0] cnt_q,
  input logic        tick
);
  AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_done_i |=> status_q[4]); // R5

  AST_ACK_CLEARS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 3'd1) |=> (mask_q == 16'h0000)); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0 && wdata_txdone_i && !tx_done_i) |=> !status_q[2]); // R2

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q != 16'h0000 && !(wr_en_i && addr_i == 3'd3))
      |=> (cnt_q == $past(cnt_q) - 16'd1)); // R6

  AST_SOFT_ONLY_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[6]) |-> ($past(cnt_q) == 16'd1)); // R7

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 16'h0000) |-> !irq_o); // R3
endmodule

bind rxim_ctrl rxim_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .addr_i         (addr_i),
  .wdata_txdone_i (wdata_i[2]),
  .rx_dma_done_i  (rx_dma_done_i),
  .tx_done_i      (tx_done_i),
  .irq_o          (irq_o),
  .status_q       (status_q),
  .mask_q         (mask_q),
  .cnt_q          (cnt_q),
  .tick           (tick)
);

// File: tb/rxim_ctrl_test.sv
module rxim_ctrl_test;
  import rxim_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  P0 = 320;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        rx_dma_done_i = 1'b0, tx_dma_done_i = 1'b0, tx_done_i = 1'b0;
  logic        stats_oflow_i = 1'b0, host_err_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rxim_ctrl uut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wdata_i = 16'h0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // ev: 0 rx, 1 txdma, 2 txdone, 3 stats, 4 host
  task automatic pulse(input logic [4:0] ev);
    @(negedge clk_i);
    rx_dma_done_i = ev[0]; tx_dma_done_i = ev[1]; tx_done_i = ev[2];
    stats_oflow_i = ev[3]; host_err_i = ev[4];
    @(posedge clk_i); #1;
    {rx_dma_done_i, tx_dma_done_i, tx_done_i, stats_oflow_i, host_err_i} = '0;
  endtask

  task automatic clear_all();
    do_write(A_MASK, 16'h0);
    do_write(A_STATUS, 16'hFFFF);
    do_write(A_COUNT, 16'h0);
    do_write(A_RATE, 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1", "irq during reset", {15'h0, irq_o}, 16'h0);
    #(CLK_PERIOD * 3);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R1", "status", d, 16'h0);
    peek(A_MASK, d);   check("R1", "mask", d, 16'h0);
    peek(A_COUNT, d);  check("R1", "countdown", d, 16'h0);
    peek(A_RATE, d);   check("R1", "rate", d, 16'h0);
    check("R1", "irq", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_events_w1c();
    logic [15:0] d;
    pulse(5'b00001);
    peek(A_STATUS, d); check("R2", "rx bit4", d, 16'h0010);
    pulse(5'b11110);
    peek(A_STATUS, d); check("R2", "all hw causes", d, 16'h003E);
    do_write(A_STATUS, 16'h0008);
    peek(A_STATUS, d); check("R2", "w1c txdma", d, 16'h0036);
    do_write(A_STATUS, 16'hFFFF);
    peek(A_STATUS, d); check("R2", "w1c all", d, 16'h0);
  endtask

  task automatic t_mask_irq();
    logic [15:0] d;
    pulse(5'b00100);
    check("R3", "irq masked", {15'h0, irq_o}, 16'h0);
    peek(A_STATUS, d); check("R3", "bit0 masked", d, 16'h0004);
    do_write(A_MASK, 16'hFFFF);
    peek(A_MASK, d); check("R3", "mask readback", d, 16'h007E);
    check("R3", "irq enabled", {15'h0, irq_o}, 16'h1);
    peek(A_STATUS, d); check("R3", "bit0 enabled", d, 16'h0005);
    clear_all();
  endtask

  task automatic t_ack();
    logic [15:0] d;
    do_write(A_MASK, 16'h003E);
    pulse(5'b11000);
    check("R4", "irq before ack", {15'h0, irq_o}, 16'h1);
    do_read(A_ACK, d); check("R4", "ack return", d, 16'h0023);
    peek(A_STATUS, d); check("R4", "status after ack", d, 16'h0);
    peek(A_MASK, d);   check("R4", "mask after ack", d, 16'h0);
    check("R4", "irq after ack", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(5'b00010);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = A_ACK; tx_done_i = 1'b1;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0; tx_done_i = 1'b0;
    peek(A_STATUS, d); check("R5", "event beats ack", d, 16'h0004);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = A_STATUS; wdata_i = 16'hFFFF; rx_dma_done_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wdata_i = 16'h0; rx_dma_done_i = 1'b0;
    peek(A_STATUS, d); check("R5", "event beats w1c", d, 16'h0010);
    clear_all();
  endtask

  task automatic t_countdown();
    logic [15:0] d;
    int n;
    n = int'(usecs_to_ticks(150));
    do_write(A_COUNT, 16'(n));
    repeat (P0) @(posedge clk_i); #1;
    peek(A_COUNT, d); check("R6", "one tick", d, 16'(n - 1));
    repeat ((n - 1) * P0 - 1) @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R6", "soft one edge early", d & 16'h0040, 16'h0);
    @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R6", "soft at expiry", d & 16'h0040, 16'h0040);
    peek(A_COUNT, d);  check("R6", "count at zero", d, 16'h0);
    do_write(A_STATUS, 16'h0040);
    repeat (3 * P0) @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R6", "single expiry", d, 16'h0);
  endtask

  task automatic t_cancel();
    logic [15:0] d;
    do_write(A_COUNT, 16'd5);
    repeat (2 * P0) @(posedge clk_i);
    do_write(A_COUNT, 16'd0);
    repeat (8 * P0) @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R7", "no soft after cancel", d, 16'h0);
    peek(A_COUNT, d);  check("R7", "count stays 0", d, 16'h0);
  endtask

  task automatic t_rate();
    logic [15:0] d;
    do_write(A_RATE, 16'h0001);
    peek(A_RATE, d); check("R8", "rate readback", d, 16'h0001);
    do_write(A_COUNT, 16'd2);
    repeat (4 * P0 - 1) @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R8", "rate1 early", d & 16'h0040, 16'h0);
    @(posedge clk_i); #1;
    peek(A_STATUS, d); check("R8", "rate1 expiry", d & 16'h0040, 16'h0040);
    clear_all();
  endtask

  task automatic t_moderation();
    logic [15:0] d;
    int n;
    check("R9", "150us ticks", 16'(usecs_to_ticks(150)), 16'd46);
    check("R9", "0us ticks", 16'(usecs_to_ticks(0)), 16'd0);
    n = int'(usecs_to_ticks(10));
    do_write(A_MASK, 16'h004E);
    do_write(A_COUNT, 16'(n));
    pulse(5'b00001);
    check("R9", "rx held off", {15'h0, irq_o}, 16'h0);
    repeat (n * P0 - 3) @(posedge clk_i); #1;
    check("R9", "still held", {15'h0, irq_o}, 16'h0);
    repeat (2) @(posedge clk_i); #1;
    check("R9", "irq on expiry", {15'h0, irq_o}, 16'h1);
    do_read(A_ACK, d); check("R9", "ack after expiry", d, 16'h0051);
    do_write(A_MASK, 16'h005E);
    pulse(5'b00001);
    check("R9", "rx direct", {15'h0, irq_o}, 16'h1);
    clear_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_events_w1c();
    t_mask_irq();
    t_ack();
    t_collision();
    t_countdown();
    t_cancel();
    t_rate();
    t_moderation();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule